// File: doc/BRIEF.md
# Byte-bus to ATA bridge decoder

This block sits on an 8-bit host bus with a 20-bit address and claims one 16 KB window of that address space. Inside the window, a small register area is forwarded to a 16-bit ATA task-file interface, and every other read is answered from an on-card boot ROM. The window base comes from a 5-bit jumper value that is captured only while reset is asserted. Reads outside the window hand back whatever the surrounding bus already carries, and writes outside the window are dropped.

The ATA data port is 16 bits wide, but the host moves one byte at a time. A 16-bit word latch joins the two halves. On reads, the high-byte address fetches the whole word from the drive and the low-byte address only reads the latch. On writes, the high-byte address only fills the latch and the low-byte address completes the word and sends it. All other register-area addresses reach single-byte task-file registers on either chip-select.

The host places one request per access and waits for a one-cycle ready pulse before it places the next. An ATA access holds its chip-select and strobe for a fixed, parameterised number of clocks, and ready follows once the strobe has ended.

Top module: `hostbus_ata_bridge`

## Requirements
- R1: The window tag (address bits [19:14]) is {j4, j4, j3..j0} of the jumper value j, captured only while rst_n is low. A jumper change without reset has no effect. The default jumper value 0x03 puts the window at 0x0C000, and jumper 0x15 puts it at 0xD4000.
- R2: A request whose address bits [19:14] differ from the window tag causes no ATA access. A write of this kind changes no state. A read of this kind returns host_bus_in, captured in the request cycle.
- R3: A window address whose bits [13:8] are not all ones is ROM space. A read there returns the ROM byte at offset o = address bits [ROM_AW-1:0], which is o[7:0] XOR (o>>8)[7:0] XOR 0x5A. A write there has no effect at all.
- R4: In the register area (bits [13:8] all ones), only address bits [3:0] are decoded. A read at nibble 0x0 returns the low byte of chip-select-1 register 7. A read at nibble 0xE or 0xF returns the low byte of chip-select-1 register 5.
- R5: A read at nibble 0x8, 0xA or 0xC does a 16-bit read of chip-select-0 register 0. It returns bits [15:8] of that word and stores the whole word in the word latch.
- R6: A read at nibble 0x9, 0xB or 0xD returns bits [7:0] of the word latch and makes no ATA access.
- R7: A write at nibble 0x8, 0xA or 0xC replaces only latch bits [15:8] and makes no ATA access. A write at nibble 0x9, 0xB or 0xD replaces latch bits [7:0] and then writes the whole latch to chip-select-0 register 0.
- R8: A write at nibble 0x0, 0xE or 0xF writes chip-select-1 register 5. Any other nibble (0x1 to 0x7) reads or writes chip-select-0 register number address bits [2:0]. Byte writes drive ata_wdata as {0x00, data}, and byte reads return ata_rdata[7:0].
- R9: During an ATA access exactly one chip-select is high. One strobe (read or write) stays high for STROBE_CYCLES clocks with the address stable. host_ready is a single-cycle pulse in the cycle after the strobe falls.
- R10: Reset clears the word latch to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; jumper value captured while low |
| jumper_cfg | input | 5 | Window base jumpers |
| host_sel | input | 1 | Host request valid |
| host_rd | input | 1 | Read request |
| host_wr | input | 1 | Write request |
| host_addr | input | 20 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_bus_in | input | 8 | Bus value returned for reads outside the window |
| host_rdata | output | 8 | Read result, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| ata_cs0 | output | 1 | ATA chip-select 0 (active high) |
| ata_cs1 | output | 1 | ATA chip-select 1 (active high) |
| ata_addr | output | 3 | ATA register number |
| ata_rd_stb | output | 1 | ATA read strobe (active high) |
| ata_wr_stb | output | 1 | ATA write strobe (active high) |
| ata_wdata | output | 16 | ATA write data |
| ata_rdata | input | 16 | ATA read data, sampled on the last strobe clock |

## Verification
The assertions assume that the host raises a request only while the block is idle and not in its ready cycle, that host_rd and host_wr are never both high, and that jumper_cfg holds steady through reset. The bench's driver task issues each request for exactly one clock, then waits for ready and one further clock before the next request, and it changes the jumpers only outside reset. The ATA side is a bench model that returns data coded by chip-select and register, so a response from the wrong register shows up as a wrong byte.

// File: rtl/bridge_pkg.sv
// Package: shared types for the byte-bus to ATA bridge.
// Assumes a 20-bit host address split into a 6-bit window tag,
// a 6-bit area field and a low nibble.
package bridge_pkg;

    // Where a decoded request is served
    typedef enum logic [1:0] {
        RT_PASS  = 2'd0,   // outside the window
        RT_ROM   = 2'd1,   // boot ROM read
        RT_ATA   = 2'd2,   // needs an ATA strobe cycle
        RT_LOCAL = 2'd3    // served by local state only
    } route_e;

    // What the word latch does for a request
    typedef enum logic [2:0] {
        LAT_NONE  = 3'd0,
        LAT_LOAD  = 3'd1,  // word read: store full ATA word
        LAT_GETLO = 3'd2,  // return low byte
        LAT_PUTHI = 3'd3,  // replace high byte
        LAT_SEND  = 3'd4   // replace low byte, write the word
    } lat_op_e;

    typedef struct packed {
        route_e     route;
        lat_op_e    lat;
        logic       cs1;
        logic [2:0] regn;
        logic       wr;
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROM  = 2'd1,
        ST_ATA  = 2'd2
    } state_e;

    // Window tag from jumpers: low four bits direct, bit 4 sets the top pair
    function automatic logic [5:0] tag_from_jumper(input logic [4:0] j);
        return {j[4], j[4], j[3:0]};
    endfunction

endpackage

// File: rtl/bridge_win_decode.sv
// Module: bridge_win_decode
// Captures the window tag from the jumpers during reset and classifies
// each host request (pass-through, ROM, ATA register, local latch op).
// Assumes the caller only uses the decode in the cycle a request is accepted.
module bridge_win_decode
    import bridge_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int AREA_W = 6,
    parameter int JMP_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [JMP_W-1:0]  jumper,
    input  logic [TAG_W-1:0]  addr_tag,
    input  logic [AREA_W-1:0] addr_area,
    input  logic [3:0]        addr_nib,
    input  logic              is_wr,
    output logic [TAG_W-1:0]  base_tag,
    output op_t               op
);

    localparam logic [AREA_W-1:0] AREA_REGS = {AREA_W{1'b1}};

    logic [TAG_W-1:0] base_q;
    logic             hit;
    logic             in_regs;

    // Capture the window tag only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= tag_from_jumper(jumper);
        end
    end

    assign base_tag = base_q;
    assign hit      = (addr_tag == base_q);
    assign in_regs  = (addr_area == AREA_REGS);

    // Classify the request into a route and latch operation
    always_comb begin
        op       = '0;
        op.route = RT_PASS;
        op.lat   = LAT_NONE;
        op.wr    = is_wr;
        if (hit) begin
            if (!in_regs) begin
                op.route = is_wr ? RT_LOCAL : RT_ROM;
            end else if (!is_wr) begin
                unique case (addr_nib)
                    4'h0: begin
                        op.route = RT_ATA; op.cs1 = 1'b1; op.regn = 3'd7;
                    end
                    4'hE, 4'hF: begin
                        op.route = RT_ATA; op.cs1 = 1'b1; op.regn = 3'd5;
                    end
                    4'h8, 4'hA, 4'hC: begin
                        op.route = RT_ATA; op.regn = 3'd0; op.lat = LAT_LOAD;
                    end
                    4'h9, 4'hB, 4'hD: begin
                        op.route = RT_LOCAL; op.lat = LAT_GETLO;
                    end
                    default: begin
                        op.route = RT_ATA; op.regn = addr_nib[2:0];
                    end
                endcase
            end else begin
                unique case (addr_nib)
                    4'h0, 4'hE, 4'hF: begin
                        op.route = RT_ATA; op.cs1 = 1'b1; op.regn = 3'd5;
                    end
                    4'h8, 4'hA, 4'hC: begin
                        op.route = RT_LOCAL; op.lat = LAT_PUTHI;
                    end
                    4'h9, 4'hB, 4'hD: begin
                        op.route = RT_ATA; op.regn = 3'd0; op.lat = LAT_SEND;
                    end
                    default: begin
                        op.route = RT_ATA; op.regn = addr_nib[2:0];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/bridge_boot_rom.sv
// Module: bridge_boot_rom
// Synchronous boot ROM with computed contents; the window offset aliases
// onto 2**ROM_AW bytes. Assumes ROM_AW is at least 8.
module bridge_boot_rom #(
    parameter int ROM_AW = 10
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ROM_AW-1:0] addr,
    output logic [7:0]        q
);

    localparam int DEPTH = 1 << ROM_AW;

    logic [7:0] mem [DEPTH];

    // Fill contents: low byte XOR upper byte XOR a fixed key
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [ROM_AW-1:0] o;
            o      = ROM_AW'(i);
            mem[i] = o[7:0] ^ 8'(o >> 8) ^ 8'h5A;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rd_en) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/bridge_ata_seq.sv
// Module: bridge_ata_seq
// Runs one ATA register cycle: chip-select, address and one strobe held
// for STB clocks. Assumes start only arrives while idle.
module bridge_ata_seq #(
    parameter int STB = 3,
    parameter int DW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sel_cs1,
    input  logic [2:0]    regn,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          ata_cs0,
    output logic          ata_cs1,
    output logic [2:0]    ata_addr,
    output logic          ata_rd_stb,
    output logic          ata_wr_stb,
    output logic [DW-1:0] ata_wdata,
    output logic          last
);

    localparam int CW = (STB > 1) ? $clog2(STB) + 1 : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(STB - 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic          cs1_q;
    logic          wr_q;
    logic [2:0]    reg_q;
    logic [DW-1:0] wdata_q;

    assign last = busy && (cnt == '0);

    // Track the strobe window length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
        end else if (last) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Hold the target register and write word for the whole cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs1_q   <= 1'b0;
            wr_q    <= 1'b0;
            reg_q   <= '0;
            wdata_q <= '0;
        end else if (start) begin
            cs1_q   <= sel_cs1;
            wr_q    <= wr;
            reg_q   <= regn;
            wdata_q <= wdata;
        end
    end

    assign ata_cs0    = busy && !cs1_q;
    assign ata_cs1    = busy && cs1_q;
    assign ata_addr   = reg_q;
    assign ata_rd_stb = busy && !wr_q;
    assign ata_wr_stb = busy && wr_q;
    assign ata_wdata  = wdata_q;

endmodule

// File: rtl/hostbus_ata_bridge.sv
// Module: hostbus_ata_bridge (top)
// Maps a jumper-selected 16 KB window of an 8-bit host bus onto a 16-bit
// ATA task file and a boot ROM, joining byte pairs through a word latch.
// Assumes one request at a time, raised only when idle and not ready.
module hostbus_ata_bridge
    import bridge_pkg::*;
#(
    parameter int STROBE_CYCLES = 3,
    parameter int ROM_AW        = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  jumper_cfg,
    input  logic        host_sel,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [19:0] host_addr,
    input  logic [7:0]  host_wdata,
    input  logic [7:0]  host_bus_in,
    output logic [7:0]  host_rdata,
    output logic        host_ready,
    output logic        ata_cs0,
    output logic        ata_cs1,
    output logic [2:0]  ata_addr,
    output logic        ata_rd_stb,
    output logic        ata_wr_stb,
    output logic [15:0] ata_wdata,
    input  logic [15:0] ata_rdata
);

    localparam int AW     = 20;
    localparam int WIN_AW = 14;
    localparam int TAG_W  = AW - WIN_AW;
    localparam int AREA_W = WIN_AW - 8;

    state_e          state;
    op_t             op;
    logic [TAG_W-1:0] base_tag;
    logic            accept;
    logic            is_wr;
    logic            rom_rd;
    logic [7:0]      rom_q;
    logic            ata_start;
    logic            ata_last;
    logic [15:0]     ata_word_out;
    logic [15:0]     word_latch;
    logic            pend_wr;
    lat_op_e         pend_lat;

    assign is_wr  = host_wr && !host_rd;
    assign accept = (state == ST_IDLE) && !host_ready && host_sel
                    && (host_rd || host_wr);

    bridge_win_decode #(
        .TAG_W  (TAG_W),
        .AREA_W (AREA_W),
        .JMP_W  (5)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .jumper    (jumper_cfg),
        .addr_tag  (host_addr[AW-1:WIN_AW]),
        .addr_area (host_addr[WIN_AW-1:8]),
        .addr_nib  (host_addr[3:0]),
        .is_wr     (is_wr),
        .base_tag  (base_tag),
        .op        (op)
    );

    assign rom_rd = accept && (op.route == RT_ROM);

    bridge_boot_rom #(
        .ROM_AW (ROM_AW)
    ) u_rom (
        .clk   (clk),
        .rd_en (rom_rd),
        .addr  (host_addr[ROM_AW-1:0]),
        .q     (rom_q)
    );

    assign ata_start    = accept && (op.route == RT_ATA);
    assign ata_word_out = (op.lat == LAT_SEND) ? {word_latch[15:8], host_wdata}
                                               : {8'h00, host_wdata};

    bridge_ata_seq #(
        .STB (STROBE_CYCLES),
        .DW  (16)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ata_start),
        .sel_cs1    (op.cs1),
        .regn       (op.regn),
        .wr         (op.wr),
        .wdata      (ata_word_out),
        .ata_cs0    (ata_cs0),
        .ata_cs1    (ata_cs1),
        .ata_addr   (ata_addr),
        .ata_rd_stb (ata_rd_stb),
        .ata_wr_stb (ata_wr_stb),
        .ata_wdata  (ata_wdata),
        .last       (ata_last)
    );

    // Sequence one access and raise the single-cycle ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            host_ready <= 1'b0;
            pend_wr    <= 1'b0;
            pend_lat   <= LAT_NONE;
        end else begin
            host_ready <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pend_wr  <= op.wr;
                        pend_lat <= op.lat;
                        unique case (op.route)
                            RT_ROM:  state <= ST_ROM;
                            RT_ATA:  state <= ST_ATA;
                            default: host_ready <= 1'b1;
                        endcase
                    end
                end
                ST_ROM: begin
                    state      <= ST_IDLE;
                    host_ready <= 1'b1;
                end
                ST_ATA: begin
                    if (ata_last) begin
                        state      <= ST_IDLE;
                        host_ready <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Load the read result for the completing access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (accept && !op.wr && (op.route == RT_PASS)) begin
            host_rdata <= host_bus_in;
        end else if (accept && (op.lat == LAT_GETLO)) begin
            host_rdata <= word_latch[7:0];
        end else if (state == ST_ROM) begin
            host_rdata <= rom_q;
        end else if ((state == ST_ATA) && ata_last && !pend_wr) begin
            host_rdata <= (pend_lat == LAT_LOAD) ? ata_rdata[15:8]
                                                 : ata_rdata[7:0];
        end
    end

    // Maintain the 16-bit word latch that joins byte pairs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_latch <= '0;
        end else if (accept && (op.lat == LAT_PUTHI)) begin
            word_latch[15:8] <= host_wdata;
        end else if (accept && (op.lat == LAT_SEND)) begin
            word_latch[7:0] <= host_wdata;
        end else if ((state == ST_ATA) && ata_last && (pend_lat == LAT_LOAD)) begin
            word_latch <= ata_rdata;
        end
    end

endmodule

// File: rtl/bridge_chk.sv
// Module: bridge_chk
// Property checker for hostbus_ata_bridge, attached by bind below.
// Assumes a request is raised only while the bridge is idle.
module bridge_chk #(
    parameter int STB = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       accept,
    input logic       host_rd,
    input logic       host_wr,
    input logic [5:0] addr_tag,
    input logic [5:0] addr_area,
    input logic [3:0] addr_nib,
    input logic [5:0] base_tag,
    input logic       host_ready,
    input logic       ata_cs0,
    input logic       ata_cs1,
    input logic       ata_rd_stb,
    input logic       ata_wr_stb
);

    localparam int RW = $clog2(STB + 2) + 1;

    logic          any_stb;
    logic [RW-1:0] run;
    logic          in_regs;
    logic          nib_hi;
    logic          nib_lo;

    assign any_stb = ata_rd_stb || ata_wr_stb;
    assign in_regs = (addr_tag == base_tag) && (addr_area == 6'h3F);
    assign nib_hi  = (addr_nib == 4'h8) || (addr_nib == 4'hA) || (addr_nib == 4'hC);
    assign nib_lo  = (addr_nib == 4'h9) || (addr_nib == 4'hB) || (addr_nib == 4'hD);

    // Count consecutive strobe clocks
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= '0;
        else if (any_stb) run <= run + 1'b1;
        else              run <= '0;
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ata_cs0, ata_cs1})); // R9
    AST_STB_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n) any_stb |-> (ata_cs0 || ata_cs1)); // R9
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ata_rd_stb && ata_wr_stb)); // R9
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) host_ready |=> !host_ready); // R9
    AST_READY_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ata_rd_stb) || $fell(ata_wr_stb)) |-> host_ready); // R9
    AST_STB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (!any_stb && (run != '0)) |-> (run == RW'(STB))); // R9
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n) $stable(base_tag)); // R1
    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (accept && (addr_tag != base_tag)) |=> !any_stb); // R2
    AST_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n) (accept && host_rd && in_regs && nib_hi) |=> (ata_rd_stb && ata_cs0)); // R5
    AST_LO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (accept && host_rd && in_regs && nib_lo) |=> !any_stb); // R6
    AST_HI_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (accept && host_wr && !host_rd && in_regs && nib_hi) |=> !any_stb); // R7

endmodule

bind hostbus_ata_bridge bridge_chk #(.STB(STROBE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .addr_tag   (host_addr[19:14]),
    .addr_area  (host_addr[13:8]),
    .addr_nib   (host_addr[3:0]),
    .base_tag   (base_tag),
    .host_ready (host_ready),
    .ata_cs0    (ata_cs0),
    .ata_cs1    (ata_cs1),
    .ata_rd_stb (ata_rd_stb),
    .ata_wr_stb (ata_wr_stb)
);

// File: tb/sim_hostbus_ata_bridge.sv
// Scoreboard bench: the driver queues the expected read byte of each access,
// the monitor compares it on host_ready; an ATA device model logs cycles.
module sim_hostbus_ata_bridge;

    localparam int STB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  jumper_cfg = 5'h03;
    logic        host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_bus_in = 8'h77;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic        ata_cs0, ata_cs1, ata_rd_stb, ata_wr_stb;
    logic [2:0]  ata_addr;
    logic [15:0] ata_wdata, ata_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hostbus_ata_bridge #(.STROBE_CYCLES(STB), .ROM_AW(10)) u0 (.*);

    // ATA device model: data coded by chip-select and register
    logic [15:0] dev_word = 16'h0000;
    always_comb begin
        if (ata_cs1)                    ata_rdata = {8'h00, 8'hC0 | {5'b0, ata_addr}};
        else if (ata_addr == 3'd0)      ata_rdata = dev_word;
        else                            ata_rdata = {8'h00, 8'hA0 | {5'b0, ata_addr}};
    end

    int          rd_cnt = 0, wr_cnt = 0, run = 0, last_width = 0;
    logic        prev_any = 1'b0, last_cs1 = 1'b0;
    logic [2:0]  last_reg = '0;
    logic [15:0] last_wdata = '0;
    always @(posedge clk) begin
        prev_any <= ata_rd_stb | ata_wr_stb;
        if ((ata_rd_stb | ata_wr_stb) && !prev_any) begin
            if (ata_rd_stb) rd_cnt <= rd_cnt + 1;
            if (ata_wr_stb) wr_cnt <= wr_cnt + 1;
            last_cs1   <= ata_cs1;
            last_reg   <= ata_addr;
            last_wdata <= ata_wdata;
        end
        if (ata_rd_stb | ata_wr_stb) run <= run + 1;
        else if (prev_any) begin last_width <= run; run <= 0; end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct { bit chk; logic [7:0] exp; string req; } item_t;
    item_t sbq[$];

    // Monitor: pop one expected item per ready pulse
    always @(negedge clk) begin
        if (rst_n && host_ready) begin
            if (sbq.size() == 0) check("R9 unexpected ready", 16'd1, 16'd0);
            else begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk) check(it.req, {8'h00, host_rdata}, {8'h00, it.exp});
            end
        end
    end

    task automatic access(input bit rd, input logic [19:0] a, input logic [7:0] d,
                          input logic [7:0] exp, input string req);
        item_t it;
        it.chk = rd; it.exp = exp; it.req = req;
        @(negedge clk);
        sbq.push_back(it);
        host_sel = 1'b1; host_rd = rd; host_wr = !rd; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
        while (!host_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [19:0] a, input logic [7:0] exp, input string req);
        access(1'b1, a, 8'h00, exp, req);
    endtask

    task automatic do_wr(input logic [19:0] a, input logic [7:0] d, input string req);
        access(1'b0, a, d, 8'h00, req);
    endtask

    function automatic logic [7:0] rom_exp(input logic [19:0] a);
        logic [9:0] o;
        o = a[9:0];
        return o[7:0] ^ {6'b0, o[9:8]} ^ 8'h5A;
    endfunction

    task automatic do_reset(input logic [4:0] j);
        @(negedge clk);
        jumper_cfg = j;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int r0, w0;
        do_reset(5'h03);
        check("R9 reset ready low", {15'b0, host_ready}, 16'd0);
        check("R9 reset no chip-select", {14'b0, ata_cs0, ata_cs1}, 16'd0);

        // R10 latch is zero after reset; R6 no ATA access on low read
        r0 = rd_cnt;
        do_rd(20'h0FF09, 8'h00, "R10 latch reset");
        check("R6 low read makes no ATA access", 16'(rd_cnt), 16'(r0));

        // R3 ROM reads at default window 0x0C000 (R1)
        do_rd(20'h0C123, rom_exp(20'h0C123), "R3 rom read");
        do_rd(20'h0FEFF, rom_exp(20'h0FEFF), "R3 rom read below regs");
        do_rd(20'h0C3C5, rom_exp(20'h0C3C5), "R1 default window rom");

        // R2 pass-through outside the window
        host_bus_in = 8'h77;
        do_rd(20'h10123, 8'h77, "R2 pass-through above");
        host_bus_in = 8'h3C;
        do_rd(20'h08F00, 8'h3C, "R2 pass-through below");

        // R4 chip-select-1 reads
        do_rd(20'h0FF00, 8'hC7, "R4 nibble 0 reads cs1 reg7");
        check("R4 cs1 selected", {15'b0, last_cs1}, 16'd1);
        check("R4 register 7", {13'b0, last_reg}, 16'd7);
        do_rd(20'h0FF0E, 8'hC5, "R4 nibble E reads cs1 reg5");
        do_rd(20'h0FF0F, 8'hC5, "R4 nibble F reads cs1 reg5");

        // R5 word read high byte, R6 low byte from latch
        dev_word = 16'hBEEF;
        r0 = rd_cnt;
        do_rd(20'h0FF0A, 8'hBE, "R5 word read high byte");
        check("R5 one ATA read", 16'(rd_cnt), 16'(r0 + 1));
        check("R5 cs0 register 0", {12'b0, last_cs1, last_reg}, 16'd0);
        dev_word = 16'h0000;
        do_rd(20'h0FF0D, 8'hEF, "R6 latch low byte");
        check("R6 no ATA read for low byte", 16'(rd_cnt), 16'(r0 + 1));

        // R2 write outside window changes nothing
        w0 = wr_cnt;
        do_wr(20'h1FF09, 8'h11, "R2 outside write");
        check("R2 outside write no ATA", 16'(wr_cnt), 16'(w0));
        do_rd(20'h0FF0B, 8'hEF, "R2 latch untouched by outside write");

        // R7 high write local, low write sends the word
        do_wr(20'h0FF08, 8'h12, "R7 high write");
        check("R7 high write no ATA", 16'(wr_cnt), 16'(w0));
        do_rd(20'h0FF09, 8'hEF, "R7 high write leaves low byte");
        do_wr(20'h0FF0B, 8'h34, "R7 low write");
        check("R7 low write one ATA write", 16'(wr_cnt), 16'(w0 + 1));
        check("R7 word sent", last_wdata, 16'h1234);
        check("R7 cs0 register 0", {12'b0, last_cs1, last_reg}, 16'd0);
        do_wr(20'h0FF0C, 8'h56, "R7 high write again");
        do_rd(20'h0FF0D, 8'h34, "R7 low byte kept");

        // R8 byte register accesses
        do_wr(20'h0FF0E, 8'h9A, "R8 write nibble E");
        check("R8 nibble E cs1 reg5", {12'b0, last_cs1, last_reg}, 16'h000D);
        check("R8 byte write data", last_wdata, 16'h009A);
        do_wr(20'h0FF00, 8'h11, "R8 write nibble 0");
        check("R8 nibble 0 cs1 reg5", {12'b0, last_cs1, last_reg}, 16'h000D);
        do_wr(20'h0FF03, 8'h44, "R8 write nibble 3");
        check("R8 nibble 3 cs0 reg3", {12'b0, last_cs1, last_reg}, 16'h0003);
        check("R8 nibble 3 data", last_wdata, 16'h0044);
        do_rd(20'h0FF06, 8'hA6, "R8 read nibble 6");
        check("R8 nibble 6 cs0 reg6", {12'b0, last_cs1, last_reg}, 16'h0006);
        do_rd(20'h0FF07, 8'hA7, "R8 read nibble 7");

        // R3 ROM write ignored
        w0 = wr_cnt;
        do_wr(20'h0C050, 8'hFF, "R3 rom write");
        check("R3 rom write no ATA", 16'(wr_cnt), 16'(w0));
        do_rd(20'h0C050, rom_exp(20'h0C050), "R3 rom unchanged");
        do_rd(20'h0FF09, 8'h34, "R3 rom write leaves latch");

        // R9 strobe width
        check("R9 strobe width", 16'(last_width), 16'(STB));

        // R1 jumper change without reset has no effect
        jumper_cfg = 5'h15;
        do_rd(20'h0FF00, 8'hC7, "R1 window held without reset");
        do_reset(5'h15);
        host_bus_in = 8'h5E;
        do_rd(20'h0C123, 8'h5E, "R1 old window now outside");
        do_rd(20'hD4123, rom_exp(20'hD4123), "R1 new window rom");
        do_rd(20'hD7F00, 8'hC7, "R1 new window regs");
        do_rd(20'hD7F09, 8'h00, "R10 latch cleared by reset");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule